// File: doc/BRIEF.md
# Self-Routing Cell Crossbar Element

This block is one element of a cell-synchronous switching fabric. It has a parameterized number of byte-wide input ports and the same number of output ports (four by default). A frame-start pulse, shared by every port, marks the start of each cell frame. A fixed number of cycles after that pulse, every input that holds a pending cell raises its valid flag and presents a routing tag byte. The tag names the output the cell wants and whether the cell uses a reserved (priority) slot.

The element decodes the tags and resolves each output that is claimed by more than one input. It then switches each winning input to its output for the remainder of the cell. The tag byte is consumed here, so the first byte a downstream stage sees is its own tag. Partway through the frame, each input receives a one-cycle acknowledge. The acknowledge says whether its cell won its output and whether that output could take the cell. An input whose cell was refused keeps the cell and decides for itself when to try again.

Each output keeps a round-robin pointer. The pointer moves only when a frame actually had competing requests, so an uncontended output does not disturb the rotation for later frames. A priority request always beats a plain request for the same output. When several priority requests compete, the same rotation chooses between them.

Top module: `selfroute_xbar`

## Requirements
- R1: A frame starts on the clock edge where `frame_start` is high. The cycle after that edge is frame cycle 0. Tags and `in_valid` are sampled only in frame cycle TAG_OFS (default 2). A tag presented in any other cycle has no effect: no output carries data and no acknowledge is raised.
- R2: Tag byte encoding. Bits [1:0] give the requested output. Bit 2 is the priority flag. Bits [7:3] are ignored. An input takes part in a frame only if `in_valid` is high in the tag cycle.
- R3: The tag byte is never forwarded. A winning input's bytes from frame cycles TAG_OFS+1 to TAG_OFS+BODY_LEN appear unchanged on its output one cycle later. `out_valid` is therefore high in frame cycles TAG_OFS+2 to TAG_OFS+BODY_LEN+1 inclusive, without a gap.
- R4: When an output has several eligible requesters, the winner is the first requesting input after the output's pointer, counting upward modulo 4.
- R5: An output's pointer takes the winner's index only when two or more inputs requested that output in the frame. After reset every pointer holds 3, so input 0 wins the first contention.
- R6: If any requester of an output has the priority flag set, only priority requesters are eligible. Ties among them follow R4.
- R7: An output that granted no input in the frame keeps `out_valid` low and `out_data` at zero for the whole frame.
- R8: `in_ack[i]` is high only in frame cycle ACK_SLOT (default 8). It is high when input i won its output and that output's `out_ready` was high in frame cycle ACK_SLOT-1. Readiness in other cycles has no effect. A granted cell is still forwarded when it is not acknowledged.
- R9: Reset (`rst_n` low) clears all grants, drives `out_valid`, `out_data` and `in_ack` to zero, and restores the pointers of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame pulse shared by all ports |
| in_valid | input | PORTS | Per input: a cell is present, sampled in the tag cycle |
| in_data | input | PORTS x DATA_W | Per input byte stream: tag byte, then cell body |
| in_ack | output | PORTS | Per input acceptance pulse in frame cycle ACK_SLOT |
| out_ready | input | PORTS | Per output: downstream buffer can accept a cell |
| out_valid | output | PORTS | Per output: a forwarded body byte is present |
| out_data | output | PORTS x DATA_W | Per output byte stream, tag removed |

## Verification
The bench drives a sequence of frames in which the rotation state carries from one frame to the next. A pointer that also moved on an uncontended frame, or that picked the pointer's own input instead of the one after it, would therefore send a later cell to the wrong port. Priority frames are built so that plain rotation would choose a different input, which exposes a priority flag that is ignored or read from the wrong bit. Readiness is made to differ between the sampling cycle and the rest of the frame, and tags are moved one cycle early or late. An element that samples in the wrong cycle would then acknowledge or route cells it should not. A reset in the middle of the run checks that the rotation returns to its start.

// File: rtl/selfroute_xbar_pkg.sv
package selfroute_xbar_pkg;

   localparam int DEF_PORTS     = 4;
   localparam int DEF_DATA_W    = 8;
   localparam int DEF_TAG_OFS   = 2;
   localparam int DEF_BODY_LEN  = 54;   // next-stage tag plus 53-byte cell
   localparam int DEF_FRAME_LEN = 64;
   localparam int DEF_ACK_SLOT  = 8;

   // width of the output-select field; the priority flag sits just above it
   function automatic int sel_width(input int ports);
      return (ports < 2) ? 1 : $clog2(ports);
   endfunction

endpackage

// File: rtl/srx_frame_timer.sv
module srx_frame_timer #(
   parameter int FRAME_LEN = 64,
   localparam int CNT_W    = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= LAST;
      else if (frame_start) cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/srx_rr_arbiter.sv
module srx_rr_arbiter #(
   parameter int PORTS   = 4,
   localparam int IDX_W  = $clog2(PORTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             update,
   input  logic [PORTS-1:0] req,
   input  logic [PORTS-1:0] pri,
   output logic [PORTS-1:0] gnt
);
   logic [IDX_W-1:0] ptr;
   logic [IDX_W-1:0] win_idx;
   logic [IDX_W-1:0] idx;
   logic [PORTS-1:0] eff;
   logic             found;

   always_comb begin
      eff     = (|(req & pri)) ? (req & pri) : req;
      gnt     = '0;
      win_idx = '0;
      idx     = '0;
      found   = 1'b0;
      for (int k = 1; k <= PORTS; k++) begin
         idx = ptr + IDX_W'(k);
         if (!found && eff[idx]) begin
            found      = 1'b1;
            gnt[idx]   = 1'b1;
            win_idx    = idx;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= IDX_W'(PORTS - 1);
      else if (update && ($countones(req) > 1))
         ptr <= win_idx;
   end
endmodule

// File: rtl/selfroute_xbar.sv
module selfroute_xbar #(
   parameter int PORTS     = selfroute_xbar_pkg::DEF_PORTS,
   parameter int DATA_W    = selfroute_xbar_pkg::DEF_DATA_W,
   parameter int TAG_OFS   = selfroute_xbar_pkg::DEF_TAG_OFS,
   parameter int BODY_LEN  = selfroute_xbar_pkg::DEF_BODY_LEN,
   parameter int FRAME_LEN = selfroute_xbar_pkg::DEF_FRAME_LEN,
   parameter int ACK_SLOT  = selfroute_xbar_pkg::DEF_ACK_SLOT
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          frame_start,
   input  logic [PORTS-1:0]              in_valid,
   input  logic [PORTS-1:0][DATA_W-1:0]  in_data,
   output logic [PORTS-1:0]              in_ack,
   input  logic [PORTS-1:0]              out_ready,
   output logic [PORTS-1:0]              out_valid,
   output logic [PORTS-1:0][DATA_W-1:0]  out_data
);
   localparam int IDX_W = selfroute_xbar_pkg::sel_width(PORTS);
   localparam int CNT_W = $clog2(FRAME_LEN);

   // elaboration-time parameter checks
   if ((1 << IDX_W) != PORTS || PORTS < 2) begin : g_bad_ports
      $error("PORTS must be a power of two of at least 2");
   end
   if (DATA_W < IDX_W + 1) begin : g_bad_width
      $error("DATA_W too narrow for select field and priority flag");
   end
   if (FRAME_LEN < TAG_OFS + BODY_LEN + 2) begin : g_bad_frame
      $error("FRAME_LEN too short for tag offset and body");
   end
   if (ACK_SLOT <= TAG_OFS + 1 || ACK_SLOT >= FRAME_LEN) begin : g_bad_ack
      $error("ACK_SLOT must fall after the tag cycle and inside the frame");
   end

   logic [CNT_W-1:0] cnt;
   logic             tag_go, body_win, ack_prep;

   srx_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cnt(cnt)
   );

   assign tag_go   = (cnt == CNT_W'(TAG_OFS)) && !frame_start;
   assign body_win = (cnt > CNT_W'(TAG_OFS)) && (cnt <= CNT_W'(TAG_OFS + BODY_LEN)) && !frame_start;
   assign ack_prep = (cnt == CNT_W'(ACK_SLOT - 1)) && !frame_start;

   logic [PORTS-1:0][PORTS-1:0] req, pri, gnt_c, gnt_q;   // [output][input]
   logic [PORTS-1:0][IDX_W-1:0] dst_q;
   logic [PORTS-1:0]            won;
   logic [PORTS-1:0][DATA_W-1:0] mux;

   // one arbiter per output
   for (genvar o = 0; o < PORTS; o++) begin : g_out
      for (genvar i = 0; i < PORTS; i++) begin : g_in
         assign req[o][i] = tag_go && in_valid[i] && (in_data[i][IDX_W-1:0] == IDX_W'(o));
         assign pri[o][i] = in_data[i][IDX_W];
      end

      srx_rr_arbiter #(.PORTS(PORTS)) u_arb (
         .clk(clk), .rst_n(rst_n), .update(tag_go),
         .req(req[o]), .pri(pri[o]), .gnt(gnt_c[o])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           gnt_q[o] <= '0;
         else if (frame_start) gnt_q[o] <= '0;
         else if (tag_go)      gnt_q[o] <= gnt_c[o];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid[o] <= 1'b0;
            out_data[o]  <= '0;
         end else begin
            out_valid[o] <= body_win && (|gnt_q[o]);
            out_data[o]  <= (body_win && (|gnt_q[o])) ? mux[o] : '0;
         end
      end
   end

   // AND-OR crossbar selection driven by the one-hot grant rows
   always_comb begin
      for (int o = 0; o < PORTS; o++) begin
         mux[o] = '0;
         for (int i = 0; i < PORTS; i++)
            if (gnt_q[o][i]) mux[o] = mux[o] | in_data[i];
      end
   end

   always_comb begin
      won = '0;
      for (int o = 0; o < PORTS; o++)
         won = won | gnt_q[o];
   end

   for (genvar i = 0; i < PORTS; i++) begin : g_ack
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      dst_q[i] <= '0;
         else if (tag_go) dst_q[i] <= in_data[i][IDX_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) in_ack[i] <= 1'b0;
         else        in_ack[i] <= ack_prep && won[i] && out_ready[dst_q[i]];
      end
   end
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int PORTS    = 4,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 6,
   parameter int TAG_OFS  = 2,
   parameter int BODY_LEN = 54,
   parameter int ACK_SLOT = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          frame_start,
   input logic [CNT_W-1:0]              cnt,
   input logic [PORTS-1:0]              out_valid,
   input logic [PORTS-1:0][DATA_W-1:0]  out_data,
   input logic [PORTS-1:0]              in_ack,
   input logic [PORTS-1:0][PORTS-1:0]   gnt_q
);
   logic [PORTS-1:0][PORTS-1:0] col;   // [input][output]

   always_comb begin
      for (int i = 0; i < PORTS; i++)
         for (int o = 0; o < PORTS; o++)
            col[i][o] = gnt_q[o][i];
   end

   AST_ACK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (|in_ack) |-> (int'(cnt) == ACK_SLOT));   // R8

   for (genvar o = 0; o < PORTS; o++) begin : g_o
      AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(gnt_q[o]));   // R4

      AST_OUT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[o] |-> (int'(cnt) >= TAG_OFS + 2 && int'(cnt) <= TAG_OFS + BODY_LEN + 1));   // R3

      AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[o] && !frame_start && int'(cnt) < TAG_OFS + BODY_LEN + 1) |=> out_valid[o]);   // R3

      AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid[o] |-> (out_data[o] == '0));   // R7
   end

   for (genvar i = 0; i < PORTS; i++) begin : g_i
      AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(col[i]));   // R2

      AST_ACK_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
         in_ack[i] |-> (|col[i]));   // R8
   end
endmodule

bind selfroute_xbar srx_checker #(
   .PORTS(PORTS), .DATA_W(DATA_W), .CNT_W(CNT_W),
   .TAG_OFS(TAG_OFS), .BODY_LEN(BODY_LEN), .ACK_SLOT(ACK_SLOT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cnt(cnt),
   .out_valid(out_valid), .out_data(out_data), .in_ack(in_ack), .gnt_q(gnt_q)
);

// File: tb/tb_selfroute_xbar.sv
`timescale 1ns/1ps
module tb_selfroute_xbar;
   localparam int PORTS = 4, DATA_W = 8, OFS = 2, BODY = 54, FLEN = 64, ACKS = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 1'b0;
   logic [PORTS-1:0] in_valid = '0;
   logic [PORTS-1:0][DATA_W-1:0] in_data = '0;
   logic [PORTS-1:0] in_ack;
   logic [PORTS-1:0] out_ready = '0;
   logic [PORTS-1:0] out_valid;
   logic [PORTS-1:0][DATA_W-1:0] out_data;

   int checks = 0, failures = 0, fnum = 0;

   always #10 clk = ~clk;   // 50 MHz

   selfroute_xbar #(.PORTS(PORTS), .DATA_W(DATA_W), .TAG_OFS(OFS),
      .BODY_LEN(BODY), .FRAME_LEN(FLEN), .ACK_SLOT(ACKS)) dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
      .in_data(in_data), .in_ack(in_ack), .out_ready(out_ready),
      .out_valid(out_valid), .out_data(out_data));

   // src code 4 means the output stays idle for the frame
   typedef struct packed {
      logic [3:0]      valid;
      logic [3:0][1:0] dest;
      logic [3:0]      pri;
      logic [3:0]      ready;
      logic [3:0]      ack;
      logic [3:0][2:0] src;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VEC [NVEC] = '{
      '{4'b1111, 8'b11_10_01_00, 4'b0000, 4'b1111, 4'b1111, 12'b011_010_001_000}, // R2 one-to-one
      '{4'b1111, 8'b00_00_00_00, 4'b0000, 4'b1111, 4'b0001, 12'b100_100_100_000}, // R4 R5 ptr 3 -> 0
      '{4'b1111, 8'b00_00_00_00, 4'b0000, 4'b1111, 4'b0010, 12'b100_100_100_001}, // R4 0 -> 1
      '{4'b1001, 8'b00_00_00_00, 4'b0000, 4'b1111, 4'b1000, 12'b100_100_100_011}, // R4 skip idle
      '{4'b0110, 8'b00_00_00_00, 4'b0100, 4'b1111, 4'b0100, 12'b100_100_100_010}, // R6 pri wins
      '{4'b1001, 8'b01_00_00_00, 4'b0000, 4'b1111, 4'b1001, 12'b100_100_011_000}, // R5 no contention
      '{4'b1011, 8'b00_00_00_00, 4'b0000, 4'b1111, 4'b1000, 12'b100_100_100_011}, // R5 ptr held at 2
      '{4'b0111, 8'b00_11_10_10, 4'b0011, 4'b0111, 4'b0001, 12'b010_000_100_100}, // R6 R8 full out3
      '{4'b1111, 8'b10_10_10_10, 4'b1010, 4'b1111, 4'b0010, 12'b100_001_100_100}, // R6 pri tie rr
      '{4'b0000, 8'b00_00_00_00, 4'b0000, 4'b1111, 4'b0000, 12'b100_100_100_100}  // R7 all idle
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_frame(input vec_t v, input int tag_at, input logic [3:0] rdy_late,
                            input string req);
      logic [3:0] ack_seen;
      int         stray;
      int         oerr [PORTS];
      logic [8:0] bad_act [PORTS];
      logic [8:0] bad_exp [PORTS];
      logic       exp_v;
      logic [7:0] exp_d;
      ack_seen = '0;
      stray = 0;
      for (int o = 0; o < PORTS; o++) begin
         oerr[o] = 0; bad_act[o] = '0; bad_exp[o] = '0;
      end
      @(negedge clk);
      frame_start = 1'b1; in_valid = '0; in_data = '0; out_ready = v.ready;
      @(negedge clk);
      frame_start = 1'b0;
      for (int c = 0; c < FLEN; c++) begin
         for (int o = 0; o < PORTS; o++) begin
            exp_v = (v.src[o] != 3'd4) && (c >= OFS + 2) && (c <= OFS + BODY + 1);
            exp_d = exp_v ? 8'(32'(v.src[o]) * 64 + 32'(c - OFS - 1)) : 8'h00;
            if (out_valid[o] !== exp_v || out_data[o] !== exp_d) begin
               if (oerr[o] == 0) begin
                  bad_act[o] = {out_valid[o], out_data[o]};
                  bad_exp[o] = {exp_v, exp_d};
               end
               oerr[o]++;
            end
         end
         if (c == ACKS) ack_seen = in_ack;
         else if (in_ack != '0) stray++;
         for (int i = 0; i < PORTS; i++) begin
            if (c == tag_at)
               in_data[i] = {5'(i * 7 + fnum), v.pri[i], v.dest[i]};
            else if (c > OFS && c <= OFS + BODY)
               in_data[i] = 8'(i * 64 + (c - OFS));
            else
               in_data[i] = 8'h00;
         end
         in_valid  = (c == tag_at) ? v.valid : 4'b0000;
         out_ready = (c == ACKS - 1) ? rdy_late : v.ready;
         @(negedge clk);
      end
      in_valid = '0; in_data = '0;
      check(ack_seen === v.ack, req, $sformatf("R8 ack vector frame %0d", fnum),
            32'(ack_seen), 32'(v.ack));
      check(stray == 0, "R8", $sformatf("ack outside slot frame %0d", fnum),
            32'(stray), 32'd0);
      for (int o = 0; o < PORTS; o++)
         check(oerr[o] == 0, (v.src[o] == 3'd4) ? "R7" : "R3",
               $sformatf("%s output %0d frame %0d", req, o, fnum),
               32'(bad_act[o]), 32'(bad_exp[o]));
      fnum++;
   endtask

   vec_t d;

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid === '0, "R9", "reset out_valid", 32'(out_valid), 32'd0);
      check(in_ack === '0, "R9", "reset in_ack", 32'(in_ack), 32'd0);
      check(out_data === '0, "R9", "reset out_data", out_data, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int n = 0; n < NVEC; n++)
         run_frame(VEC[n], OFS, VEC[n].ready, "R4/R5/R6");

      // R1: tag one cycle early / late is not seen
      d = '{4'b0001, 8'b00_00_00_00, 4'b0000, 4'b1111, 4'b0000, 12'b100_100_100_100};
      run_frame(d, OFS + 1, 4'b1111, "R1 late tag");
      run_frame(d, OFS - 1, 4'b1111, "R1 early tag");

      // R8: readiness only counts in the cycle before the ack slot
      d = '{4'b0001, 8'b00_00_01_01, 4'b0000, 4'b0000, 4'b0001, 12'b100_100_000_100};
      run_frame(d, OFS, 4'b0010, "R8 late ready");
      d = '{4'b0001, 8'b00_00_01_01, 4'b0000, 4'b0010, 4'b0000, 12'b100_100_000_100};
      run_frame(d, OFS, 4'b0000, "R8 ready drop");

      // R5 / R9: pointer returns to 3 after reset
      d = '{4'b1111, 8'b00_00_00_00, 4'b0000, 4'b1111, 4'b0001, 12'b100_100_100_000};
      run_frame(d, OFS, 4'b1111, "R5 before reset");
      d = '{4'b1111, 8'b00_00_00_00, 4'b0000, 4'b1111, 4'b0010, 12'b100_100_100_001};
      run_frame(d, OFS, 4'b1111, "R5 advance");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check(out_valid === '0 && in_ack === '0, "R9", "mid-run reset outputs",
            32'({out_valid, in_ack}), 32'd0);
      rst_n = 1'b1;
      d = '{4'b1111, 8'b00_00_00_00, 4'b0000, 4'b1111, 4'b0001, 12'b100_100_100_000};
      run_frame(d, OFS, 4'b1111, "R9 pointer reset");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 20);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule